// File: doc/BRIEF.md
# Board Control Register Block

This block is a set of memory-mapped control registers for a small evaluation board. It sits on a simple 32-bit bus that has a single request strobe. Only the low 20 address bits take part in decode. Every read returns its data, and its error flag, in the cycle after the request.

The block holds:
- an 8-bit LED bar register;
- an eight-character text buffer. It can be filled in one write, where a 32-bit word is turned into uppercase hexadecimal text, or changed one character at a time;
- a software reset trigger;
- a switch register that always reads as zero;
- a general-purpose output byte;
- four registers that bit-bang a two-wire serial bus: line enables, line levels, line input and bus select.

An attached serial EEPROM slave is modelled inside the block as an enumerated state machine. Software drives the clock and data levels through the line-level register. It reads the slave's data-out bit back through the line-input register.

The slave state machine has eight states:
- IDLE: waits for a start condition.
- CMD: shifts in the command byte.
- CMD_ACK: drives the acknowledge low.
- ADDR: shifts in the word address.
- ADDR_ACK: drives the acknowledge low.
- HOLD: waits for a repeated start or a stop.
- READ: shifts a data byte out, MSB first.
- READ_ACK: samples the master's acknowledge.

Transitions:
- A start condition moves any state to CMD.
- A stop condition moves any state to IDLE.
- On a rising clock:
  - CMD goes to CMD_ACK after eight bits.
  - CMD_ACK goes to READ when the command's low bit is 1, and to ADDR otherwise.
  - ADDR goes to ADDR_ACK after eight bits.
  - ADDR_ACK goes to HOLD.
  - READ goes to READ_ACK after eight bits.
  - READ_ACK goes back to READ, with the address incremented, when the master drives a low acknowledge. It goes to HOLD when the master leaves the line high.

Top module: `bdctl_top`

## Requirements
- R1: Register decode uses only `bus_addr[19:0]`. An access at `0xBF000408` or at `0x00100408` reaches the LED register, exactly as `0x00408` does.
- R2: After reset:
  - `led_o` is 0.
  - Every byte of `disp_o` is `0x20` (space).
  - `gpo_o`, `i2c_oe_o`, `i2c_sel_o`, `reset_req_o` and `bus_err` are 0.
  - The line-level register holds `2'b11`.
- R3: The LED register (offset `0x00408`) keeps the low 8 bits of a write. Reading it returns those 8 bits, zero-extended, and `led_o` shows them. `led_o` changes only after a write to this register.
- R4: A write to the hex-word register (offset `0x00410`; reads return 0) fills all eight characters. Position 0 (`disp_o[7:0]`) takes the most significant nibble and position 7 the least. A nibble 0–9 becomes `0x30+n` and a nibble 10–15 becomes `0x37+n`, which gives uppercase A–F.
- R5: A write to offset `0x418 + 8*i` (i = 0..7) stores the low byte in character position i (`disp_o[8*i +: 8]`) only. A read of that offset returns the stored byte.
- R6: The switch register (offset `0x00200`) always reads 0. Writes to it have no effect and raise no error.
- R7: These registers keep the listed bits of a write and read back zero-extended:
  - general-purpose output (`0x00A00`): 8 bits;
  - line enable (`0x00B08`): 2 bits;
  - bus select (`0x00B18`): 1 bit.
- R8: Any write to the reset register (`0x00500`) raises `reset_req_o` for exactly one cycle, in the cycle after the request. Reads of this register return 0.
- R9: A write to the line-level register (`0x00B10`) carries the clock level in bit 1 and the data level in bit 0, and every such write is passed to the slave. A read of the line-input register (`0x00B00`) returns:
  - bit 1: the last clock level written;
  - bit 0: the slave's data-out bit, which is 1 while the slave is idle.
- R10: Start and stop are recognised while the clock stays high:
  - a start is data falling from 1 to 0;
  - a stop is data rising from 0 to 1.
  On a rising clock the slave shifts in a command byte; only its low bit (1 = read) matters. It pulls data-out low through the acknowledge clock, and for a write command it then takes an 8-bit word address and acknowledges it.
- R11: After a read command, the byte at word address a is `{a[3:0],a[7:4]} ^ 8'h5A`, sent MSB first. Bit k is valid from the rising edge that ends the previous bit until the rising edge of bit k. A low master acknowledge moves to address a+1, wrapping from 255 to 0. A high acknowledge ends the transfer with data-out at 1.
- R12: An access to any other offset returns 0 and raises `bus_err` for one cycle, in the cycle after the request. A write to such an offset changes no output.
- R13: Read data and `bus_err` are registered. They are valid in the cycle after the request, and `bus_rdata` is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; low 20 bits are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_err | output | 1 | Unmapped-offset pulse, the cycle after the request |
| led_o | output | 8 | LED bar state |
| disp_o | output | 64 | Eight text characters, position i at bits 8i+7:8i |
| gpo_o | output | 8 | General-purpose output byte |
| i2c_oe_o | output | 2 | Serial-bus line enables |
| i2c_sel_o | output | 1 | Serial-bus select |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume three things about the bus:
- it carries at most one access per cycle, and `bus_req` is low during reset;
- address, direction and data are known whenever `bus_req` is high;
- the slave sees clock and data changes only as whole line-level writes, so a start or stop is recognised only between two consecutive writes.

The stimulus meets these assumptions in the following way:
- all bus signals are driven from a single task, at the falling clock edge;
- each access is followed by an idle cycle;
- serial-bus traffic uses only these sequences:
  - the start sequence: clock high with data high, then clock high with data low;
  - the stop sequence: data low, then clock high, then data high;
  - data bits, each changed while the clock is low and then clocked by a separate high write.

// File: rtl/bdctl_pkg.sv
package bdctl_pkg;

    localparam int DEC_BITS    = 20;
    localparam int CHAR_SHIFT  = 3;

    localparam logic [DEC_BITS-1:0] OFF_SWITCH  = 20'h00200;
    localparam logic [DEC_BITS-1:0] OFF_LED     = 20'h00408;
    localparam logic [DEC_BITS-1:0] OFF_WORD    = 20'h00410;
    localparam logic [DEC_BITS-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [DEC_BITS-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [DEC_BITS-1:0] OFF_GPO     = 20'h00A00;
    localparam logic [DEC_BITS-1:0] OFF_I2C_IN  = 20'h00B00;
    localparam logic [DEC_BITS-1:0] OFF_I2C_OE  = 20'h00B08;
    localparam logic [DEC_BITS-1:0] OFF_I2C_OUT = 20'h00B10;
    localparam logic [DEC_BITS-1:0] OFF_I2C_SEL = 20'h00B18;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_LED,
        SEL_WORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_GPO,
        SEL_I2C_IN,
        SEL_I2C_OE,
        SEL_I2C_OUT,
        SEL_I2C_SEL
    } reg_sel_e;

    typedef enum logic [2:0] {
        EE_IDLE,
        EE_CMD,
        EE_CMD_ACK,
        EE_ADDR,
        EE_ADDR_ACK,
        EE_HOLD,
        EE_READ,
        EE_READ_ACK
    } ee_state_e;

    // Uppercase hexadecimal digit for one nibble.
    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        if (nib < 4'd10) return 8'h30 + {4'h0, nib};
        else             return 8'h37 + {4'h0, nib};
    endfunction

endpackage

// File: rtl/bdctl_decode.sv
module bdctl_decode
    import bdctl_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    localparam int IDX_W = $clog2(NUM_CHARS)
) (
    input  logic [DEC_BITS-1:0] offset_i,
    output reg_sel_e            sel_o,
    output logic [IDX_W-1:0]    idx_o
);

    localparam logic [DEC_BITS-1:0] CHAR_END =
        OFF_CHAR0 + DEC_BITS'(NUM_CHARS << CHAR_SHIFT);

    logic [DEC_BITS-1:0] char_span;
    logic                in_char;

    assign char_span = offset_i - OFF_CHAR0;
    assign in_char   = (offset_i >= OFF_CHAR0) && (offset_i < CHAR_END)
                       && (char_span[CHAR_SHIFT-1:0] == '0);
    assign idx_o     = char_span[CHAR_SHIFT +: IDX_W];

    always_comb begin
        if (in_char) begin
            sel_o = SEL_CHAR;
        end else begin
            unique case (offset_i)
                OFF_SWITCH:  sel_o = SEL_SWITCH;
                OFF_LED:     sel_o = SEL_LED;
                OFF_WORD:    sel_o = SEL_WORD;
                OFF_SOFTRST: sel_o = SEL_SOFTRST;
                OFF_GPO:     sel_o = SEL_GPO;
                OFF_I2C_IN:  sel_o = SEL_I2C_IN;
                OFF_I2C_OE:  sel_o = SEL_I2C_OE;
                OFF_I2C_OUT: sel_o = SEL_I2C_OUT;
                OFF_I2C_SEL: sel_o = SEL_I2C_SEL;
                default:     sel_o = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bdctl_disp.sv
module bdctl_disp
    import bdctl_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    parameter int CHAR_W    = 8,
    localparam int IDX_W  = $clog2(NUM_CHARS),
    localparam int NIB_W  = 4,
    localparam int WORD_W = NUM_CHARS * NIB_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        word_we_i,
    input  logic [WORD_W-1:0]           word_i,
    input  logic                        char_we_i,
    input  logic [IDX_W-1:0]            char_idx_i,
    input  logic [CHAR_W-1:0]           char_i,
    output logic [NUM_CHARS*CHAR_W-1:0] text_o
);

    localparam logic [CHAR_W-1:0] BLANK = CHAR_W'(8'h20);

    for (genvar g = 0; g < NUM_CHARS; g++) begin : g_pos
        logic [CHAR_W-1:0] ch_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q <= BLANK;
            end else if (word_we_i) begin
                ch_q <= CHAR_W'(hex_char(word_i[WORD_W-1-g*NIB_W -: NIB_W]));
            end else if (char_we_i && (char_idx_i == IDX_W'(g))) begin
                ch_q <= char_i;
            end
        end

        assign text_o[g*CHAR_W +: CHAR_W] = ch_q;
    end

    // R4: after a word write every position holds a hex digit
    logic all_hex;
    always_comb begin
        all_hex = 1'b1;
        for (int i = 0; i < NUM_CHARS; i++) begin
            if (!((text_o[i*CHAR_W +: CHAR_W] >= CHAR_W'(8'h30) &&
                   text_o[i*CHAR_W +: CHAR_W] <= CHAR_W'(8'h39)) ||
                  (text_o[i*CHAR_W +: CHAR_W] >= CHAR_W'(8'h41) &&
                   text_o[i*CHAR_W +: CHAR_W] <= CHAR_W'(8'h46))))
                all_hex = 1'b0;
        end
    end

    a_r4_word_gives_hex: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_we_i) |-> all_hex);

endmodule

// File: rtl/bdctl_eeprom.sv
module bdctl_eeprom
    import bdctl_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [7:0]  ROM_XOR = 8'h5A,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sdo_o
);

    localparam int HALF = BYTE_W / 2;

    ee_state_e          st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [BYTE_W-2:0]  sh_q, sh_d;
    logic               rw_q, rw_d;
    logic [BYTE_W-1:0]  addr_q, addr_d;
    logic [BYTE_W-1:0]  data_q, data_d;
    logic               scl_q, sda_q;
    logic               start_c, stop_c, rise_c;

    // Stored contents are a fixed function of the word address.
    function automatic logic [BYTE_W-1:0] rom_byte(input logic [BYTE_W-1:0] a);
        return {a[HALF-1:0], a[BYTE_W-1:HALF]} ^ BYTE_W'(ROM_XOR);
    endfunction

    assign start_c = wr_stb_i && scl_q && scl_i && sda_q && !sda_i;
    assign stop_c  = wr_stb_i && scl_q && scl_i && !sda_q && sda_i;
    assign rise_c  = wr_stb_i && !scl_q && scl_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= EE_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            rw_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            rw_q   <= rw_d;
            addr_q <= addr_d;
            data_q <= data_d;
            if (wr_stb_i) begin
                scl_q <= scl_i;
                sda_q <= sda_i;
            end
        end
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        rw_d   = rw_q;
        addr_d = addr_q;
        data_d = data_q;
        if (start_c) begin
            st_d  = EE_CMD;
            cnt_d = '0;
        end else if (stop_c) begin
            st_d  = EE_IDLE;
            cnt_d = '0;
        end else if (rise_c) begin
            unique case (st_q)
                EE_CMD: begin
                    sh_d  = {sh_q[BYTE_W-3:0], sda_i};
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(BYTE_W-1)) begin
                        st_d = EE_CMD_ACK;
                        rw_d = sda_i;
                    end
                end
                EE_CMD_ACK: begin
                    cnt_d = '0;
                    if (rw_q) begin
                        st_d   = EE_READ;
                        data_d = rom_byte(addr_q);
                    end else begin
                        st_d = EE_ADDR;
                    end
                end
                EE_ADDR: begin
                    sh_d  = {sh_q[BYTE_W-3:0], sda_i};
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(BYTE_W-1)) begin
                        st_d   = EE_ADDR_ACK;
                        addr_d = {sh_q, sda_i};
                    end
                end
                EE_ADDR_ACK: st_d = EE_HOLD;
                EE_READ: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(BYTE_W-1)) st_d = EE_READ_ACK;
                end
                EE_READ_ACK: begin
                    if (!sda_i) begin
                        st_d   = EE_READ;
                        cnt_d  = '0;
                        addr_d = addr_q + 1'b1;
                        data_d = rom_byte(addr_q + 1'b1);
                    end else begin
                        st_d = EE_HOLD;
                    end
                end
                EE_IDLE, EE_HOLD: st_d = st_q;
                default:          st_d = EE_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            EE_CMD_ACK, EE_ADDR_ACK: sdo_o = 1'b0;
            EE_READ:                 sdo_o = data_q[CNT_W'(BYTE_W-1) - cnt_q];
            default:                 sdo_o = 1'b1;
        endcase
    end

    a_r10_start_enters_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && scl_q && scl_i && sda_q && !sda_i) |=> (st_q == EE_CMD));

    a_r10_stop_enters_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && scl_q && scl_i && !sda_q && sda_i) |=> (st_q == EE_IDLE && sdo_o));

    a_r9_moves_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(st_q));

endmodule

// File: rtl/bdctl_top.sv
module bdctl_top
    import bdctl_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    parameter int LED_W     = 8,
    parameter int GPO_W     = 8,
    parameter int OE_W      = 2,
    localparam int CHAR_W = 8,
    localparam int IDX_W  = $clog2(NUM_CHARS),
    localparam int LINE_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [31:0]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_err,
    output logic [LED_W-1:0]            led_o,
    output logic [NUM_CHARS*CHAR_W-1:0] disp_o,
    output logic [GPO_W-1:0]            gpo_o,
    output logic [OE_W-1:0]             i2c_oe_o,
    output logic                        i2c_sel_o,
    output logic                        reset_req_o
);

    reg_sel_e            sel;
    logic [IDX_W-1:0]    idx;
    logic                wr, rd;
    logic [LINE_W-1:0]   line_q;
    logic                sdo;
    logic [31:0]         rd_mux;
    logic                addr_hi_unused;

    assign addr_hi_unused = ^bus_addr[31:DEC_BITS];
    assign wr = bus_req && bus_we;
    assign rd = bus_req && !bus_we;

    bdctl_decode #(.NUM_CHARS(NUM_CHARS)) u_decode (
        .offset_i (bus_addr[DEC_BITS-1:0]),
        .sel_o    (sel),
        .idx_o    (idx)
    );

    bdctl_disp #(.NUM_CHARS(NUM_CHARS), .CHAR_W(CHAR_W)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we_i  (wr && sel == SEL_WORD),
        .word_i     (bus_wdata[NUM_CHARS*4-1:0]),
        .char_we_i  (wr && sel == SEL_CHAR),
        .char_idx_i (idx),
        .char_i     (bus_wdata[CHAR_W-1:0]),
        .text_o     (disp_o)
    );

    bdctl_eeprom u_eeprom (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr && sel == SEL_I2C_OUT),
        .scl_i    (bus_wdata[1]),
        .sda_i    (bus_wdata[0]),
        .sdo_o    (sdo)
    );

    // Read data selection
    always_comb begin
        unique case (sel)
            SEL_LED:     rd_mux = 32'(led_o);
            SEL_CHAR:    rd_mux = 32'(disp_o[idx*CHAR_W +: CHAR_W]);
            SEL_GPO:     rd_mux = 32'(gpo_o);
            SEL_I2C_OE:  rd_mux = 32'(i2c_oe_o);
            SEL_I2C_OUT: rd_mux = 32'(line_q);
            SEL_I2C_IN:  rd_mux = 32'({line_q[1], sdo});
            SEL_I2C_SEL: rd_mux = 32'(i2c_sel_o);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_o       <= '0;
            gpo_o       <= '0;
            i2c_oe_o    <= '0;
            i2c_sel_o   <= 1'b0;
            line_q      <= '1;
            reset_req_o <= 1'b0;
            bus_err     <= 1'b0;
            bus_rdata   <= '0;
        end else begin
            if (wr && sel == SEL_LED)     led_o     <= bus_wdata[LED_W-1:0];
            if (wr && sel == SEL_GPO)     gpo_o     <= bus_wdata[GPO_W-1:0];
            if (wr && sel == SEL_I2C_OE)  i2c_oe_o  <= bus_wdata[OE_W-1:0];
            if (wr && sel == SEL_I2C_SEL) i2c_sel_o <= bus_wdata[0];
            if (wr && sel == SEL_I2C_OUT) line_q    <= bus_wdata[LINE_W-1:0];
            reset_req_o <= wr && (sel == SEL_SOFTRST);
            bus_err     <= bus_req && (sel == SEL_NONE);
            bus_rdata   <= rd ? rd_mux : '0;
        end
    end

    a_r3_led_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr && sel == SEL_LED) |-> $stable(led_o));

    a_r8_reset_req_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(bus_req && bus_we));

    a_r12_err_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req));

    a_r13_rdata_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd) |-> (bus_rdata == '0));

endmodule

// File: tb/bdctl_top_bench.sv
module bdctl_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  led_o;
    logic [63:0] disp_o;
    logic [7:0]  gpo_o;
    logic [1:0]  i2c_oe_o;
    logic        i2c_sel_o;
    logic        reset_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    bdctl_top u_bdctl_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .led_o(led_o), .disp_o(disp_o), .gpo_o(gpo_o),
        .i2c_oe_o(i2c_oe_o), .i2c_sel_o(i2c_sel_o), .reset_req_o(reset_req_o)
    );

    localparam logic [31:0] A_SWITCH = 32'h00200, A_LED = 32'h00408,
        A_WORD = 32'h00410, A_CHAR0 = 32'h00418, A_SOFT = 32'h00500,
        A_GPO = 32'h00A00, A_IN = 32'h00B00, A_OE = 32'h00B08,
        A_OUT = 32'h00B10, A_SEL = 32'h00B18;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: pushes the expected result, then issues the read
    task automatic bus_read(input logic [31:0] a, input logic [31:0] exp,
                            input logic exp_err, input string tag);
        exp_t e;
        e.data = exp; e.err = exp_err; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // Monitor: compares results as the design produces them (R13)
    always @(posedge clk) begin
        if (bus_req && !bus_we) begin
            exp_t e;
            #5;
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R13: actual read result with no expected item, expected none");
            end else begin
                e = sb_q.pop_front();
                check({e.tag, " data"}, 64'(bus_rdata), 64'(e.data));
                check({e.tag, " err"}, 64'(bus_err), 64'(e.err));
            end
        end
    end

    function automatic logic [7:0] rom(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h5A;
    endfunction

    function automatic logic [63:0] hex_text(input logic [31:0] w);
        logic [63:0] t;
        for (int i = 0; i < 8; i++) begin
            logic [3:0] n;
            n = w[31-4*i -: 4];
            t[8*i +: 8] = (n < 10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
        end
        return t;
    endfunction

    task automatic line(input logic s, input logic d);
        bus_write(A_OUT, {30'b0, s, d});
    endtask

    task automatic line_in(input logic scl, input logic bitv, input string tag);
        bus_read(A_IN, {30'b0, scl, bitv}, 1'b0, tag);
    endtask

    task automatic i2c_start();
        line(1, 1); line(1, 0);
    endtask

    task automatic i2c_stop();
        line(0, 0); line(1, 0); line(1, 1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            line(0, b[i]); line(1, b[i]); line(0, b[i]);
        end
        line_in(0, 0, "R10 slave ack");
        line(0, 1); line(1, 1); line(0, 1);
    endtask

    task automatic recv_byte(input logic [7:0] b, input bit ack);
        for (int i = 7; i >= 0; i--) begin
            line_in(0, b[i], "R11 read bit");
            line(1, 1); line(0, 1);
        end
        line_in(0, 1, "R11 released for master ack");
        if (ack) begin
            line(0, 0); line(1, 0); line(0, 0); line(0, 1);
        end else begin
            line(0, 1); line(1, 1); line(0, 1);
        end
    endtask

    task automatic eeprom_read2(input logic [7:0] a);
        i2c_start();
        send_byte(8'hA0);
        send_byte(a);
        i2c_start();
        send_byte(8'hA1);
        recv_byte(rom(a), 1'b1);
        recv_byte(rom(a + 8'd1), 1'b0);
        line_in(0, 1, "R11 data-out high after nack");
        i2c_stop();
        line_in(1, 1, "R10 idle after stop");
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check("R2 led", 64'(led_o), 64'h0);
        check("R2 disp", disp_o, {8{8'h20}});
        check("R2 gpo", 64'(gpo_o), 64'h0);
        check("R2 oe", 64'(i2c_oe_o), 64'h0);
        check("R2 sel", 64'(i2c_sel_o), 64'h0);
        check("R2 reset_req", 64'(reset_req_o), 64'h0);
        check("R2 err", 64'(bus_err), 64'h0);
        bus_read(A_OUT, 32'h3, 1'b0, "R2 line level reset");
        line_in(1, 1, "R9 idle data-out");

        // R3: LED
        bus_write(A_LED, 32'h1234_56A5);
        check("R3 led_o", 64'(led_o), 64'hA5);
        bus_read(A_LED, 32'hA5, 1'b0, "R3 led readback");
        bus_read(A_SWITCH, 32'h0, 1'b0, "R13 read does not touch led");
        check("R3 led held", 64'(led_o), 64'hA5);

        // R1: aliasing through upper address bits
        bus_write(32'hBF00_0408, 32'h3C);
        check("R1 alias high", 64'(led_o), 64'h3C);
        bus_write(32'h0010_0408, 32'h5B);
        check("R1 alias bit20", 64'(led_o), 64'h5B);
        bus_read(32'hFFF0_0408, 32'h5B, 1'b0, "R1 alias read");

        // R4: word to hex text
        bus_write(A_WORD, 32'hDEAD_BEEF);
        check("R4 DEADBEEF", disp_o, hex_text(32'hDEAD_BEEF));
        bus_write(A_WORD, 32'h0123_4567);
        check("R4 01234567", disp_o, hex_text(32'h0123_4567));
        bus_write(A_WORD, 32'h89AB_CDEF);
        check("R4 89ABCDEF", disp_o, hex_text(32'h89AB_CDEF));
        bus_read(A_WORD, 32'h0, 1'b0, "R4 word reads zero");

        // R5: single characters
        bus_write(A_CHAR0 + 32'd24, 32'hFFFF_FF78);
        check("R5 pos3", disp_o, {hex_text(32'h89AB_CDEF)[63:32], 8'h78,
                                  hex_text(32'h89AB_CDEF)[23:0]});
        bus_write(A_CHAR0 + 32'd56, 32'h41);
        check("R5 pos7", 64'(disp_o[63:56]), 64'h41);
        bus_write(A_CHAR0, 32'h7A);
        check("R5 pos0", 64'(disp_o[7:0]), 64'h7A);
        bus_read(A_CHAR0 + 32'd24, 32'h78, 1'b0, "R5 pos3 readback");
        bus_read(A_CHAR0 + 32'd56, 32'h41, 1'b0, "R5 pos7 readback");

        // R6: switches
        bus_write(A_SWITCH, 32'hFFFF_FFFF);
        check("R6 write no err", 64'(bus_err), 64'h0);
        bus_read(A_SWITCH, 32'h0, 1'b0, "R6 switch zero");

        // R7: gpo, enables, select
        bus_write(A_GPO, 32'h0000_01FF);
        check("R7 gpo", 64'(gpo_o), 64'hFF);
        bus_write(A_OE, 32'hF);
        check("R7 oe", 64'(i2c_oe_o), 64'h3);
        bus_write(A_SEL, 32'h3);
        check("R7 sel", 64'(i2c_sel_o), 64'h1);
        bus_read(A_GPO, 32'hFF, 1'b0, "R7 gpo readback");
        bus_read(A_OE, 32'h3, 1'b0, "R7 oe readback");
        bus_read(A_SEL, 32'h1, 1'b0, "R7 sel readback");

        // R8: reset request pulse
        bus_write(A_SOFT, 32'h0);
        check("R8 pulse high", 64'(reset_req_o), 64'h1);
        @(negedge clk);
        check("R8 pulse one cycle", 64'(reset_req_o), 64'h0);
        bus_read(A_SOFT, 32'h0, 1'b0, "R8 reads zero");

        // R12: unmapped offsets
        bus_read(32'h0000_0300, 32'h0, 1'b1, "R12 unmapped read");
        bus_read(A_CHAR0 + 32'd4, 32'h0, 1'b1, "R12 misaligned char");
        bus_write(A_CHAR0 + 32'd64, 32'h55);
        check("R12 write err", 64'(bus_err), 64'h1);
        check("R12 disp untouched", 64'(disp_o[7:0]), 64'h7A);
        @(negedge clk);
        check("R12 err one cycle", 64'(bus_err), 64'h0);

        // R9, R10, R11: serial EEPROM transfers
        eeprom_read2(8'h3C);
        eeprom_read2(8'hFF);
        bus_read(A_OUT, 32'h3, 1'b0, "R9 line readback");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule